// File: doc/BRIEF.md
# Reloading 16-bit Interval Timer

The block is a 16-bit down-counter paired with a 16-bit reload latch, reached through an 8-bit byte-wide register port with four addresses. The count advances only on cycles where a clock-enable tick is high. When the count steps past zero, the block emits a one-cycle interrupt-set strobe, which goes to an interrupt flag register kept outside the block. A separate clear strobe tells that register when an access has to drop the pending timer flag.

Software arms the timer by writing a low byte to the latch, then writing the high byte at the counter-high address. That write moves the whole latch into the counter. An input mode bit selects free-running or one-shot behaviour. In free-running mode the counter runs from the latch value down through zero to all-ones, then reloads, so one period is latch + 2 ticks. In one-shot mode the counter keeps decrementing and wrapping after the first zero crossing, but it gives no further strobe until the next counter-high write.

Top module: `ivt_top`

## Requirements
- R1: After reset the latch and the counter both hold 0xFFFF, irq_set is low, and the one-shot timer is not armed.
- R2: The counter changes only on a cycle with tick_en high or on a counter-high write. Otherwise it holds its value.
- R3: A write to address 0 or address 2 replaces only the low byte of the latch and leaves the running count untouched.
- R4: A write to address 3 replaces the latch high byte, does not reload the counter, and raises flag_clr in the same cycle.
- R5: A write to address 1 replaces the latch high byte and loads the whole latch into the counter, visible the next cycle. It arms the one-shot, raises flag_clr in that cycle, and takes priority over a simultaneous tick.
- R6: With mode_free=1 the count follows latch, latch-1, …, 0, 0xFFFF, latch, so strobes repeat every latch + 2 ticks.
- R7: irq_set is high for exactly one cycle, the cycle in which the counter first shows 0xFFFF after a tick taken at zero.
- R8: With mode_free=0 the counter wraps and keeps decrementing after zero. Only the first zero crossing after a counter-high write strobes irq_set.
- R9: Reads are combinational. Address 0 returns the live count low byte and raises flag_clr. Address 1 returns the count high byte with flag_clr low. Addresses 2 and 3 return the latch low and high bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| mode_free | input | 1 | 1 = free-running, 0 = one-shot |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | 0 count low, 1 count high, 2 latch low, 3 latch high |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte |
| irq_set | output | 1 | One-cycle interrupt-set strobe |
| flag_clr | output | 1 | Timer flag clear strobe |

## Verification
The properties assume that wr_en and rd_en are never high in the same cycle. They also assume that addr and wr_data are valid whenever either strobe is high. The stimulus only issues single accesses, one per cycle. It mixes dense and sparse tick patterns, and it places counter-high writes on tick cycles. Mode changes happen only between runs, never while a check window is open.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    A_CNT_LO = 2'd0,
    A_CNT_HI = 2'd1,
    A_LAT_LO = 2'd2,
    A_LAT_HI = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ivt_latch.sv
module ivt_latch
  import ivt_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [BW-1:0] wr_data,
  output logic [CW-1:0] latch_q,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          flag_clr
);
  logic          lo_we, hi_we;
  logic [CW-1:0] latch_d;

  always_comb begin
    lo_we    = wr_en && (addr == A_CNT_LO || addr == A_LAT_LO);
    hi_we    = wr_en && (addr == A_CNT_HI || addr == A_LAT_HI);
    load     = wr_en && (addr == A_CNT_HI);
    flag_clr = hi_we || (rd_en && !wr_en && addr == A_CNT_LO);
    latch_d  = latch_q;
    if (lo_we) latch_d[BW-1:0]  = wr_data;
    if (hi_we) latch_d[CW-1:BW] = wr_data;
    load_val = {wr_data, latch_q[BW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '1;
    else if (lo_we || hi_we) latch_q <= latch_d;
  end
endmodule

// File: rtl/ivt_down.sv
module ivt_down
  import ivt_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          mode_free,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] latch,
  output logic [CW-1:0] cnt_q,
  output logic          irq_set
);
  logic [CW-1:0] cnt_d;
  logic          wrap_q, wrap_d;
  logic          arm_q, arm_d;
  logic          irq_d;
  logic          at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    cnt_d   = cnt_q;
    wrap_d  = wrap_q;
    arm_d   = arm_q;
    irq_d   = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      wrap_d = 1'b0;
      arm_d  = 1'b1;
    end else if (tick_en) begin
      if (at_zero) begin
        cnt_d  = '1;
        wrap_d = 1'b1;
        irq_d  = mode_free || arm_q;
        arm_d  = 1'b0;
      end else if (wrap_q && mode_free) begin
        cnt_d  = latch;
        wrap_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - 1'b1;
        wrap_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      wrap_q  <= 1'b0;
      arm_q   <= 1'b0;
      irq_set <= 1'b0;
    end else begin
      irq_set <= irq_d;
      if (load || tick_en) begin
        cnt_q  <= cnt_d;
        wrap_q <= wrap_d;
        arm_q  <= arm_d;
      end
    end
  end
endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux
  import ivt_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int CW = 2 * BW
) (
  input  logic [1:0]    addr,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] latch,
  output logic [BW-1:0] rd_data
);
  always_comb begin
    unique case (addr)
      A_CNT_LO: rd_data = cnt[BW-1:0];
      A_CNT_HI: rd_data = cnt[CW-1:BW];
      A_LAT_LO: rd_data = latch[BW-1:0];
      default:  rd_data = latch[CW-1:BW];
    endcase
  end
endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          mode_free,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] rd_data,
  output logic          irq_set,
  output logic          flag_clr
);
  logic [CW-1:0] latch_q, load_val, cnt_q;
  logic          load;

  ivt_latch #(.BW(BW)) latch_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .latch_q(latch_q), .load(load), .load_val(load_val),
    .flag_clr(flag_clr)
  );

  ivt_down #(.CW(CW)) down_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_free(mode_free),
    .load(load), .load_val(load_val), .latch(latch_q), .cnt_q(cnt_q),
    .irq_set(irq_set)
  );

  ivt_rdmux #(.BW(BW)) rdmux_i (
    .addr(addr), .cnt(cnt_q), .latch(latch_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [BW-1:0] wr_data,
  input logic          irq_set,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] latch
);
  logic ld;
  assign ld = wr_en && addr == 2'd1;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld) |=> $stable(cnt));

  // R5
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == {$past(wr_data), $past(latch[BW-1:0])});

  // R4
  lat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3) |=> latch[CW-1:BW] == $past(wr_data));

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> !irq_set);

  // R7
  irq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_set) |-> (cnt == '1 && $past(tick_en) && $past(cnt) == '0));
endmodule

bind ivt_top ivt_chk #(.BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .irq_set(irq_set), .cnt(cnt_q), .latch(latch_q)
);

// File: tb/ivt_top_tb_top.sv
module ivt_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, tick_en, mode_free, wr_en, rd_en;
  logic [1:0] addr;
  logic [7:0] wr_data, rd_data;
  logic       irq_set, flag_clr;

  int errors = 0, checks = 0, cycle = 0;
  int m_cnt, m_latch;
  bit m_wrap, m_arm, m_irq;
  int irq_cyc[$];

  always #5 clk = ~clk;

  ivt_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_free(mode_free),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_set(irq_set), .flag_clr(flag_clr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  // one cycle: drive at falling edge, compare, advance the model
  task automatic cyc(input bit t, input bit w, input bit r, input int a, input int d);
    int exp_rd;
    bit exp_clr;
    tick_en = t; wr_en = w; rd_en = r; addr = a[1:0]; wr_data = d[7:0];
    #1;
    check("R7 irq_set", irq_set, m_irq);
    if (irq_set) irq_cyc.push_back(cycle);
    case (a)
      0: exp_rd = m_cnt & 8'hFF;
      1: exp_rd = m_cnt >> 8;
      2: exp_rd = m_latch & 8'hFF;
      default: exp_rd = m_latch >> 8;
    endcase
    exp_clr = (w && (a == 1 || a == 3)) || (r && !w && a == 0);
    if (r) check("R9 rd_data", rd_data, exp_rd);
    if (w || r) check("R9/R4/R5 flag_clr", flag_clr, exp_clr);
    m_irq = 0;
    if (w && (a == 0 || a == 2)) m_latch = (m_latch & 16'hFF00) | d;
    if (w && a == 3) m_latch = (m_latch & 16'h00FF) | (d << 8);
    if (w && a == 1) begin
      m_latch = (m_latch & 16'h00FF) | (d << 8);
      m_cnt = m_latch; m_wrap = 0; m_arm = 1;
    end else if (t) begin
      if (m_cnt == 0) begin
        m_irq = mode_free || m_arm; m_arm = 0; m_cnt = 16'hFFFF; m_wrap = 1;
      end else if (m_wrap && mode_free) begin
        m_cnt = m_latch; m_wrap = 0;
      end else begin
        m_cnt = (m_cnt - 1) & 16'hFFFF; m_wrap = 0;
      end
    end
    @(negedge clk);
    cycle++;
  endtask

  function automatic int rd_cnt_hi_lo_dummy(input int x);
    return x;
  endfunction

  initial begin : watchdog
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; tick_en = 0; mode_free = 0; wr_en = 0; rd_en = 0;
    addr = 0; wr_data = 0;
    m_cnt = 16'hFFFF; m_latch = 16'hFFFF; m_wrap = 0; m_arm = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state, read all four addresses
    check("R1 irq_set after reset", irq_set, 0);
    for (int a = 0; a < 4; a++) cyc(0, 0, 1, a, 0);

    // R2 idle hold
    repeat (5) cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);

    // R3 low-byte writes while counting
    cyc(1, 1, 0, 2, 8'h05);
    cyc(1, 1, 0, 0, 8'h05);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 1, 2, 0);

    // R5 R6 free-running: latch 5, period 7
    mode_free = 1;
    cyc(0, 1, 0, 1, 8'h00);
    irq_cyc.delete();
    for (int i = 0; i < 40; i++) cyc(1, 0, (i % 3) == 0, i % 2, 0);
    check("R6 strobe count", irq_cyc.size(), 5);
    for (int i = 1; i < irq_cyc.size(); i++)
      check("R6 period", irq_cyc[i] - irq_cyc[i-1], 7);

    // R4 latch-high write: no reload
    cyc(1, 1, 0, 3, 8'h00);
    cyc(1, 0, 1, 3, 0);
    cyc(1, 0, 1, 0, 0);

    // R8 one-shot: single strobe after load, latch 3
    mode_free = 0;
    cyc(0, 1, 0, 2, 8'h03);
    cyc(0, 1, 0, 1, 8'h00);
    irq_cyc.delete();
    for (int i = 0; i < 30; i++) cyc(1, 0, 1, i % 2, 0);
    check("R8 one-shot strobes", irq_cyc.size(), 1);

    // R5 load coinciding with tick, then sparse ticks
    cyc(1, 1, 0, 1, 8'h00);
    cyc(0, 0, 1, 0, 0);
    irq_cyc.delete();
    for (int i = 0; i < 40; i++) cyc((i % 4) == 0, 0, 1, 0, 0);
    check("R2 sparse tick strobes", irq_cyc.size(), 1);

    // R6 latch 0 free-running: period 2
    mode_free = 1;
    cyc(0, 1, 0, 2, 8'h00);
    cyc(0, 1, 0, 1, 8'h00);
    irq_cyc.delete();
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, 0);
    for (int i = 1; i < irq_cyc.size(); i++)
      check("R6 latch-0 period", irq_cyc[i] - irq_cyc[i-1], 2);

    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 7);
      if (op == 0) cyc($urandom_range(0, 1), 1, 0, $urandom_range(0, 3), $urandom_range(0, 12));
      else cyc($urandom_range(0, 1), 0, op < 4, $urandom_range(0, 3), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule